// File: doc/BRIEF.md
# Two-Lane Running Lag Correlator

This block computes a correlation function over 100 lag points from a stream of signed 14-bit samples. Each accepted input carries one `a` sample and one `b` sample. In auto mode the `a` sample is also used as `b`, so the block computes an auto-correlation. Otherwise the two streams are cross-correlated.

A start pulse clears all state. The first 100 samples after start only fill the `b` history. The next 512 samples are accumulated:

- Samples with an even index go to lane 0 and samples with an odd index go to lane 1. The index counts from 0 at the first sample after start.
- When the odd sample of a pair arrives, the history advances by two positions.
- Both lanes then step through all 100 lags, one lag per clock. Each lane has one multiplier.

After the last pair, the two partial sums for each lag are added. The total is arithmetically shifted right by 9 (divided by 512, rounded toward minus infinity). The results leave on a valid/ready stream in lag order, and a done pulse follows the last lag.

The control is a state machine with these states and transitions:

- ST_IDLE to ST_FILL on start.
- ST_FILL to ST_WAIT after 50 history pairs.
- ST_WAIT to ST_CALC on each completed pair.
- ST_CALC back to ST_WAIT after lag 99, or to ST_EMIT after the 256th pair.
- ST_EMIT to ST_IDLE when lag 99 is accepted.
- A start pulse in any state moves the block to ST_FILL.

Top module: `lagcorr_top`

## Requirements
- R1: After reset, out_valid, done and overrun are all 0.
- R2: With k counting accepted samples from 0 after start, each result m (0..99) equals floor((sum over k=100..611 of a(k)*b(k-m)) / 512). It is presented as a 31-bit two's complement value.
- R3: The first 100 samples after start only fill the history. out_valid stays 0 until all 612 samples have been taken and the final lane pass is over.
- R4: Results appear in lag order, 0 first. out_lag is the unsigned 7-bit lag number of the result on out_data, and each accepted result advances it by one.
- R5: When auto_mode is 1 as a sample is taken, in_b is ignored and the a sample is used as the b sample.
- R6: While out_valid is 1 and out_ready is 0, out_data and out_lag hold their values and out_valid stays 1.
- R7: done is 1 for exactly the one cycle after lag 99 is accepted, and out_valid is 0 from that cycle on.
- R8: An odd-index sample that arrives while a lane pass is in progress is discarded and sets overrun. overrun stays 1 until the next start pulse clears it. Odd-index samples spaced 101 clocks or more apart never set it.
- R9: A start pulse clears all accumulated sums, so a run's results depend only on the samples of that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a new run; clears sums and overrun |
| auto_mode | input | 1 | 1: use the a sample as b (auto-correlation) |
| in_valid | input | 1 | A sample pair is present |
| in_a | input | 14 | Signed a sample |
| in_b | input | 14 | Signed b sample |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer accepts the result |
| out_lag | output | 7 | Lag number of the current result |
| out_data | output | 31 | Scaled correlation result, signed |
| done | output | 1 | One-cycle pulse after the last result |
| overrun | output | 1 | Sticky flag: a sample arrived too early |

## Verification
The block is tried with four input patterns:

- Uniform random cross-correlation, where every lag has a distinct value. A wrong lane parity, a wrong history offset or a wrong merge shows up as a lag mismatch.
- Random auto-correlation with garbage on in_b. This separates the use of a as b from the plain cross path.
- A constant full-scale negative stream. This drives every accumulator to its largest magnitude and exposes any lost sign or width.
- An alternating extreme stream. Its results change sign with the parity of the lag, which exposes rounding toward minus infinity and a lane pair that is swapped.

Random back-pressure during output checks that the results hold under a stall. A short run fed too fast sets the overrun flag, and the next start must clear it.

// File: rtl/lagcorr_pkg.sv
package lagcorr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_WAIT,
        ST_CALC,
        ST_EMIT
    } corr_state_t;
endpackage

// File: rtl/lagcorr_hist.sv
// b-sample history; two new entries are pushed at once, oldest fall off the end.
module lagcorr_hist #(
    parameter int DW    = 14,
    parameter int DEPTH = 101,
    parameter int IW    = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push,
    input  logic signed [DW-1:0] b_older,
    input  logic signed [DW-1:0] b_newer,
    input  logic [IW-1:0]        rd_idx,
    output logic signed [DW-1:0] rd_at,
    output logic signed [DW-1:0] rd_next
);
    logic signed [DW-1:0] h [DEPTH];
    logic [IW-1:0]        idx_p1;

    assign idx_p1  = rd_idx + 1'b1;
    assign rd_at   = h[rd_idx];
    assign rd_next = h[idx_p1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h[0] <= '0;
            h[1] <= '0;
        end else if (push) begin
            h[0] <= b_newer;
            h[1] <= b_older;
        end
    end

    for (genvar i = 2; i < DEPTH; i++) begin : g_tap
        always_ff @(posedge clk) begin
            if (!rst_n) h[i] <= '0;
            else if (push) h[i] <= h[i-2];
        end
    end
endmodule

// File: rtl/lagcorr_lane.sv
// One compute lane: a single multiplier and a bank of lag accumulators.
module lagcorr_lane #(
    parameter int DW   = 14,
    parameter int AW   = 40,
    parameter int LAGS = 100,
    parameter int IW   = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 en,
    input  logic [IW-1:0]        idx,
    input  logic signed [DW-1:0] a_s,
    input  logic signed [DW-1:0] b_s,
    input  logic [IW-1:0]        rd_idx,
    output logic signed [AW-1:0] rd_sum
);
    localparam int PW = 2 * DW;

    logic signed [AW-1:0] acc [LAGS];
    logic signed [PW-1:0] prod;
    logic signed [AW-1:0] prod_x;

    assign prod   = a_s * b_s;
    assign prod_x = {{(AW-PW){prod[PW-1]}}, prod};
    assign rd_sum = acc[rd_idx];

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < LAGS; i++) acc[i] <= '0;
        end else if (en) begin
            acc[idx] <= acc[idx] + prod_x;
        end
    end
endmodule

// File: rtl/lagcorr_top.sv
module lagcorr_top
    import lagcorr_pkg::*;
#(
    parameter int DW    = 14,
    parameter int AW    = 40,
    parameter int LAGS  = 100,
    parameter int LOG_N = 9,
    parameter int LW    = $clog2(LAGS + 1),
    parameter int OW    = AW - LOG_N
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          auto_mode,
    input  logic          in_valid,
    input  logic [DW-1:0] in_a,
    input  logic [DW-1:0] in_b,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [LW-1:0] out_lag,
    output logic [OW-1:0] out_data,
    output logic          done,
    output logic          overrun
);
    localparam int PAIRS      = (1 << LOG_N) / 2;
    localparam int FILL_PAIRS = LAGS / 2;
    localparam int PW         = $clog2(PAIRS + FILL_PAIRS);

    corr_state_t state, nxt;

    logic                 par;
    logic signed [DW-1:0] a_hold, b_hold, a_p0, a_p1;
    logic signed [DW-1:0] b_eff;
    logic [PW-1:0]        pair_cnt;
    logic [LW-1:0]        lag;
    logic                 ovr, done_r;
    logic                 taking, pair_done, push, calc_en, lag_last;
    logic signed [DW-1:0] h_at, h_next;
    logic signed [AW-1:0] sum0, sum1, sum_all;

    assign b_eff     = auto_mode ? $signed(in_a) : $signed(in_b);
    assign taking    = in_valid && !start &&
                       (state == ST_FILL || state == ST_WAIT || state == ST_CALC);
    assign pair_done = taking && par;
    assign lag_last  = (lag == LW'(LAGS - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: ;
            ST_FILL: if (pair_done && pair_cnt == PW'(FILL_PAIRS - 1)) nxt = ST_WAIT;
            ST_WAIT: if (pair_done) nxt = ST_CALC;
            ST_CALC: if (lag_last)
                         nxt = (pair_cnt == PW'(PAIRS - 1)) ? ST_EMIT : ST_WAIT;
            ST_EMIT: if (out_ready && lag_last) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
        if (start) nxt = ST_FILL;
    end

    // outputs and datapath controls
    always_comb begin
        out_valid = (state == ST_EMIT);
        calc_en   = (state == ST_CALC);
        push      = pair_done && (state == ST_FILL || state == ST_WAIT);
        out_lag   = lag;
        done      = done_r;
        overrun   = ovr;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par      <= 1'b0;
            a_hold   <= '0;
            b_hold   <= '0;
            a_p0     <= '0;
            a_p1     <= '0;
            pair_cnt <= '0;
            lag      <= '0;
            ovr      <= 1'b0;
            done_r   <= 1'b0;
        end else begin
            done_r <= 1'b0;
            if (start) begin
                par      <= 1'b0;
                pair_cnt <= '0;
                lag      <= '0;
                ovr      <= 1'b0;
            end else begin
                if (taking && !par) begin
                    a_hold <= $signed(in_a);
                    b_hold <= b_eff;
                    par    <= 1'b1;
                end else if (pair_done && state == ST_CALC) begin
                    ovr <= 1'b1;
                end else if (pair_done) begin
                    par  <= 1'b0;
                    a_p0 <= a_hold;
                    a_p1 <= $signed(in_a);
                end
                unique case (state)
                    ST_FILL: if (pair_done)
                                 pair_cnt <= (pair_cnt == PW'(FILL_PAIRS - 1)) ? '0 : pair_cnt + 1'b1;
                    ST_CALC: begin
                        lag <= lag_last ? '0 : lag + 1'b1;
                        if (lag_last) pair_cnt <= pair_cnt + 1'b1;
                    end
                    ST_EMIT: if (out_ready) begin
                        lag    <= lag_last ? '0 : lag + 1'b1;
                        done_r <= lag_last;
                    end
                    default: ;
                endcase
            end
        end
    end

    lagcorr_hist #(.DW(DW), .DEPTH(LAGS + 1), .IW(LW)) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push),
        .b_older (b_hold),
        .b_newer (b_eff),
        .rd_idx  (lag),
        .rd_at   (h_at),
        .rd_next (h_next)
    );

    // lane 0: even-index a against b one step older; lane 1: odd-index a
    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic signed [AW-1:0] rsum;
        lagcorr_lane #(.DW(DW), .AW(AW), .LAGS(LAGS), .IW(LW)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (start),
            .en     (calc_en),
            .idx    (lag),
            .a_s    ((g == 0) ? a_p0 : a_p1),
            .b_s    ((g == 0) ? h_next : h_at),
            .rd_idx (lag),
            .rd_sum (rsum)
        );
    end

    assign sum0     = g_lane[0].rsum;
    assign sum1     = g_lane[1].rsum;
    assign sum_all  = sum0 + sum1;
    assign out_data = sum_all[AW-1:LOG_N];
endmodule

// File: rtl/lagcorr_chk.sv
module lagcorr_chk #(
    parameter int LAGS = 100,
    parameter int LW   = 7,
    parameter int OW   = 31
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          out_valid,
    input logic          out_ready,
    input logic [LW-1:0] out_lag,
    input logic [OW-1:0] out_data,
    input logic          done,
    input logic          overrun
);
    // R4
    lag_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_lag < LW'(LAGS));

    // R4
    lag_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_lag != LW'(LAGS - 1) && !start)
            |=> (out_valid && out_lag == $past(out_lag) + 1'b1));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !start)
            |=> (out_valid && $stable(out_data) && $stable(out_lag)));

    // R7
    done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_lag == LW'(LAGS - 1) && !start) |=> (done && !out_valid));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !start) |=> overrun);

    // R8
    ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !overrun);
endmodule

bind lagcorr_top lagcorr_chk #(.LAGS(LAGS), .LW(LW), .OW(OW)) u_chk (.*);

// File: tb/tb_lagcorr_top.sv
module tb_lagcorr_top;
    localparam int LAGS = 100;
    localparam int NTOT = 612;
    localparam int GAP  = 52;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        auto_mode = 1'b0;
    logic        in_valid = 1'b0;
    logic [13:0] in_a = '0;
    logic [13:0] in_b = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [6:0]  out_lag;
    logic [30:0] out_data;
    logic        done;
    logic        overrun;

    int total = 0;
    int bad = 0;
    int sa [NTOT];
    int sb [NTOT];
    longint expv [LAGS];

    always #2 clk = ~clk;

    lagcorr_top dut (
        .clk(clk), .rst_n(rst_n), .start(start), .auto_mode(auto_mode),
        .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_ready(out_ready), .out_lag(out_lag),
        .out_data(out_data), .done(done), .overrun(overrun)
    );

    task automatic check(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rnd14();
        return int'($urandom_range(16383)) - 8192;
    endfunction

    // bench reference: floor of the lag sums over samples 100..611 divided by 512
    function automatic longint ref_lag(input int m, input bit use_a);
        longint s = 0;
        for (int k = LAGS; k < NTOT; k++)
            s += longint'(sa[k]) * longint'(use_a ? sa[k-m] : sb[k-m]);
        return s >>> 9;
    endfunction

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic feed(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_a = sa[i][13:0];
            in_b = sb[i][13:0];
            @(negedge clk);
            in_valid = 1'b0;
            repeat (gap - 2) @(negedge clk);
        end
    endtask

    task automatic run(input int kind, input bit am, input bit bp, input bit later);
        int cnt;
        bit early;
        bit pv;
        logic [30:0] pdata;
        logic [6:0] plag;
        for (int i = 0; i < NTOT; i++) begin
            unique case (kind)
                0: begin sa[i] = rnd14(); sb[i] = rnd14(); end
                1: begin sa[i] = -8192; sb[i] = -8192; end
                default: begin sa[i] = (i % 2 == 0) ? 8191 : -8192; sb[i] = rnd14(); end
            endcase
        end
        for (int m = 0; m < LAGS; m++) expv[m] = ref_lag(m, am);
        auto_mode = am;
        pulse_start();
        check("R8 start clears overrun", longint'(overrun), 0);
        early = 1'b0;
        fork
            feed(NTOT, GAP);
            begin
                for (int c = 0; c < NTOT * GAP; c++) begin
                    @(negedge clk);
                    if (out_valid) early = 1'b1;
                end
            end
        join_any
        disable fork;
        repeat (GAP) @(negedge clk);
        if (out_valid) early = 1'b0;
        check("R3 no output during fill and accumulate", longint'(early), 0);
        while (!out_valid) @(negedge clk);
        cnt = 0;
        pv = 1'b0;
        while (cnt < LAGS) begin
            @(negedge clk);
            if (pv) begin
                check("R6 hold valid", longint'(out_valid), 1);
                check("R6 hold data", longint'(out_data), longint'(pdata));
                check("R6 hold lag", longint'(out_lag), longint'(plag));
            end
            out_ready = bp ? ($urandom_range(1) == 1) : 1'b1;
            #1;
            if (out_valid && out_ready) begin
                check("R4 lag index", longint'(out_lag), longint'(cnt));
                if (later)
                    check("R9 result after restart", longint'($signed(out_data)), expv[cnt]);
                else if (am)
                    check("R5 auto result", longint'($signed(out_data)), expv[cnt]);
                else
                    check("R2 result", longint'($signed(out_data)), expv[cnt]);
                cnt++;
                pv = 1'b0;
            end else begin
                pv = out_valid;
                pdata = out_data;
                plag = out_lag;
            end
        end
        @(negedge clk);
        out_ready = 1'b0;
        check("R7 done pulse", longint'(done), 1);
        check("R7 valid low after last", longint'(out_valid), 0);
        @(negedge clk);
        check("R7 done one cycle", longint'(done), 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid", longint'(out_valid), 0);
        check("R1 done", longint'(done), 0);
        check("R1 overrun", longint'(overrun), 0);

        // R8: samples far too fast for the lane pass
        for (int i = 0; i < NTOT; i++) begin sa[i] = rnd14(); sb[i] = rnd14(); end
        pulse_start();
        feed(104, 2);
        repeat (4) @(negedge clk);
        check("R8 overrun set", longint'(overrun), 1);
        repeat (300) @(negedge clk);
        check("R8 overrun sticky", longint'(overrun), 1);

        run(0, 1'b0, 1'b1, 1'b0);   // random cross, back-pressure
        check("R8 no overrun at legal pace", longint'(overrun), 0);
        run(0, 1'b1, 1'b0, 1'b1);   // random auto, in_b garbage
        run(1, 1'b0, 1'b0, 1'b1);   // full-scale negative
        run(2, 1'b1, 1'b1, 1'b1);   // alternating extremes, auto

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule